// File: doc/BRIEF.md
# Hot-Plug Expander Synchronizer

This block keeps the hot-plug control outputs and status inputs of a set of downstream ports in step with an external I/O expander on an SMBus segment. The local policy logic drives a control vector into the block. Whenever that vector differs from the last value sent, the block asks a byte-level SMBus master engine for one write that carries the whole vector. The expander reports input changes on an active-low interrupt line. The block passes that line through a synchronizer and, while it is asserted, asks the engine for a read of the whole status vector. It then loads the result into a local status register.

Traffic starts only once a configuration-done input has been seen high after reset. At that point the block first makes one full write and then one full read, so that both sides agree from the start. One transaction is outstanding at a time. A pending write is served before a pending read. The block assumes it is the only master on the segment, so it does no arbitration. When the engine reports a failure, it reissues that transaction once and records the failure in a sticky flag.

Top module: `hpx_sync`

## Requirements
- R1: After reset, req_valid is 0, hp_sts is all zeros and err_sticky is 0.
- R2: No request is made until cfg_done has been seen high. While cfg_done stays low, neither output changes nor interrupts cause requests.
- R3: Once cfg_done has been seen high, the first transaction is a write of the current hp_ctl (req_rd = 0, req_cmd = WR_CMD). The second is a read (req_rd = 1, req_cmd = RD_CMD).
- R4: A change of hp_ctl causes exactly one write. Its req_wdata holds the full vector in bits [OUT_W-1:0] and zeros in bits [15:OUT_W].
- R5: If hp_ctl changes after a write has been launched, a second write carrying the latest hp_ctl follows when the first completes.
- R6: exp_int_n is active low. While its synchronized level is low, the block issues a read. A read that completes without error loads rsp_rdata[IN_W-1:0] into hp_sts.
- R7: If the synchronized exp_int_n is still low when a read completes, another read is issued.
- R8: When a write and a read are both pending in the same cycle, the write is issued first.
- R9: While req_valid is high and req_ack is low, req_valid and all request fields hold their values. No new request is raised between an accepted request and its rsp_done.
- R10: A completion with rsp_err high sets err_sticky, which then stays high until reset. The failed transaction is reissued exactly once. A failed read leaves hp_sts unchanged.
- R11: req_addr always equals the DEV_ADDR parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_done | input | 1 | Configuration phase finished |
| hp_ctl | input | OUT_W | Hot-plug control vector to mirror to the expander |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| hp_sts | output | IN_W | Last hot-plug status vector read from the expander |
| err_sticky | output | 1 | Set on any engine error, cleared only by reset |
| req_valid | output | 1 | Transaction request to the SMBus engine |
| req_ack | input | 1 | Engine accepted the request |
| req_addr | output | 7 | Expander device address |
| req_rd | output | 1 | 1 = read, 0 = write |
| req_cmd | output | 8 | Command byte |
| req_wdata | output | 16 | Write data word |
| rsp_done | input | 1 | One-cycle completion pulse |
| rsp_err | input | 1 | Completion failed, valid with rsp_done |
| rsp_rdata | input | 16 | Read data, valid with rsp_done |

## Verification
The bench sweeps every value of a 4-bit control vector in turn. Each step must give exactly one write carrying that value, which separates whole-vector mirroring from partial or repeated writes. It also sweeps every 4-bit status value through interrupts whose read data carries non-zero upper bits, which shows that the status register is loaded with the low slice and only on good reads. Further cases change the outputs during a write, assert the interrupt before an output change, hold the interrupt across one read, and inject one or two engine errors. Together these separate the dirty re-write, the write-first ordering, level-triggered re-reads and the single-retry limit.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
   localparam int unsigned HPX_DATA_W = 16;
   localparam int unsigned HPX_ADDR_W = 7;
   localparam int unsigned HPX_CMD_W  = 8;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } hpx_state_e;

   typedef enum logic {
      OP_WR = 1'b0,
      OP_RD = 1'b1
   } hpx_op_e;
endpackage

// File: rtl/hpx_int_sync.sv
module hpx_int_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   output logic asserted_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpx_int_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_n};
   end

   assign asserted_o = ~chain[STAGES-1];
endmodule

// File: rtl/hpx_out_track.sv
module hpx_out_track #(
   parameter int unsigned OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W-1:0] cur_i,
   input  logic             launch_i,
   output logic [OUT_W-1:0] snap_o,
   output logic             dirty_o
);
   logic [OUT_W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_q <= '0;
      else if (launch_i) snap_q <= cur_i;
   end

   assign snap_o  = snap_q;
   assign dirty_o = (cur_i != snap_q);
endmodule

// File: rtl/hpx_txn_ctl.sv
module hpx_txn_ctl
   import hpx_pkg::*;
#(
   parameter int unsigned   OUT_W    = 16,
   parameter int unsigned   IN_W     = 16,
   parameter logic [6:0]    DEV_ADDR = 7'h20,
   parameter logic [7:0]    WR_CMD   = 8'h02,
   parameter logic [7:0]    RD_CMD   = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_done,
   input  logic                  wr_dirty,
   input  logic                  rd_irq,
   input  logic [OUT_W-1:0]      snap,
   output logic                  launch_wr,
   output logic [IN_W-1:0]       sts_o,
   output logic                  err_o,
   output logic                  req_valid,
   input  logic                  req_ack,
   output logic [HPX_ADDR_W-1:0] req_addr,
   output logic                  req_rd,
   output logic [HPX_CMD_W-1:0]  req_cmd,
   output logic [HPX_DATA_W-1:0] req_wdata,
   input  logic                  rsp_done,
   input  logic                  rsp_err,
   input  logic [HPX_DATA_W-1:0] rsp_rdata
);
   hpx_state_e      state;
   hpx_op_e         op;
   logic            retried;
   logic            cfg_seen;
   logic            init_wr;
   logic            init_rd;
   logic [IN_W-1:0] sts_q;
   logic            err_q;
   logic            start_wr;
   logic            start_rd;

   assign start_wr = (state == ST_IDLE) && cfg_seen && (wr_dirty || init_wr);
   assign start_rd = (state == ST_IDLE) && cfg_seen && !start_wr && (rd_irq || init_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op       <= OP_WR;
         retried  <= 1'b0;
         cfg_seen <= 1'b0;
         init_wr  <= 1'b1;
         init_rd  <= 1'b1;
         sts_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         cfg_seen <= cfg_seen | cfg_done;
         case (state)
            ST_IDLE: begin
               if (start_wr) begin
                  op    <= OP_WR;
                  state <= ST_REQ;
               end else if (start_rd) begin
                  op    <= OP_RD;
                  state <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (req_ack) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_done) begin
                  if (rsp_err) err_q <= 1'b1;
                  if (rsp_err && !retried) begin
                     retried <= 1'b1;
                     state   <= ST_REQ;
                  end else begin
                     retried <= 1'b0;
                     state   <= ST_IDLE;
                     if (op == OP_WR) init_wr <= 1'b0;
                     else             init_rd <= 1'b0;
                     if (op == OP_RD && !rsp_err) sts_q <= rsp_rdata[IN_W-1:0];
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign launch_wr = start_wr;
   assign req_valid = (state == ST_REQ);
   assign req_rd    = (op == OP_RD);
   assign req_cmd   = (op == OP_RD) ? RD_CMD : WR_CMD;
   assign req_addr  = DEV_ADDR;
   assign sts_o     = sts_q;
   assign err_o     = err_q;

   generate
      if (OUT_W == HPX_DATA_W) begin : g_wd_full
         assign req_wdata = snap;
      end else begin : g_wd_ext
         assign req_wdata = {{(HPX_DATA_W-OUT_W){1'b0}}, snap};
      end
      if (IN_W < HPX_DATA_W) begin : g_rd_part
         logic unused_rd_hi;
         assign unused_rd_hi = ^rsp_rdata[HPX_DATA_W-1:IN_W];
      end
   endgenerate
endmodule

// File: rtl/hpx_sync.sv
module hpx_sync
   import hpx_pkg::*;
#(
   parameter int unsigned OUT_W       = 16,
   parameter int unsigned IN_W        = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ADDR    = 7'h20,
   parameter logic [7:0]  WR_CMD      = 8'h02,
   parameter logic [7:0]  RD_CMD      = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_done,
   input  logic [OUT_W-1:0] hp_ctl,
   input  logic             exp_int_n,
   output logic [IN_W-1:0]  hp_sts,
   output logic             err_sticky,
   output logic             req_valid,
   input  logic             req_ack,
   output logic [6:0]       req_addr,
   output logic             req_rd,
   output logic [7:0]       req_cmd,
   output logic [15:0]      req_wdata,
   input  logic             rsp_done,
   input  logic             rsp_err,
   input  logic [15:0]      rsp_rdata
);
   generate
      if (OUT_W < 1 || OUT_W > HPX_DATA_W) begin : g_bad_out
         $error("hpx_sync: OUT_W must be 1..16");
      end
      if (IN_W < 1 || IN_W > HPX_DATA_W) begin : g_bad_in
         $error("hpx_sync: IN_W must be 1..16");
      end
   endgenerate

   logic             irq_level;
   logic             launch_wr;
   logic [OUT_W-1:0] snap;
   logic             wr_dirty;

   hpx_int_sync #(.STAGES(SYNC_STAGES)) u_isync (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_n     (exp_int_n),
      .asserted_o (irq_level)
   );

   hpx_out_track #(.OUT_W(OUT_W)) u_otrk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_i    (hp_ctl),
      .launch_i (launch_wr),
      .snap_o   (snap),
      .dirty_o  (wr_dirty)
   );

   hpx_txn_ctl #(
      .OUT_W    (OUT_W),
      .IN_W     (IN_W),
      .DEV_ADDR (DEV_ADDR),
      .WR_CMD   (WR_CMD),
      .RD_CMD   (RD_CMD)
   ) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_done  (cfg_done),
      .wr_dirty  (wr_dirty),
      .rd_irq    (irq_level),
      .snap      (snap),
      .launch_wr (launch_wr),
      .sts_o     (hp_sts),
      .err_o     (err_sticky),
      .req_valid (req_valid),
      .req_ack   (req_ack),
      .req_addr  (req_addr),
      .req_rd    (req_rd),
      .req_cmd   (req_cmd),
      .req_wdata (req_wdata),
      .rsp_done  (rsp_done),
      .rsp_err   (rsp_err),
      .rsp_rdata (rsp_rdata)
   );
endmodule

// File: rtl/hpx_sync_chk.sv
module hpx_sync_chk #(
   parameter int unsigned OUT_W    = 16,
   parameter int unsigned IN_W     = 16,
   parameter logic [6:0]  DEV_ADDR = 7'h20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_done,
   input logic [IN_W-1:0] hp_sts,
   input logic            err_sticky,
   input logic            req_valid,
   input logic            req_ack,
   input logic [6:0]      req_addr,
   input logic            req_rd,
   input logic [7:0]      req_cmd,
   input logic [15:0]     req_wdata,
   input logic            rsp_done,
   input logic            rsp_err,
   input logic [15:0]     rsp_rdata
);
   logic            cfg_ever;
   logic            busy;
   logic            busy_rd;
   logic [IN_W-1:0] rd_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_ever <= 1'b0;
         busy     <= 1'b0;
         busy_rd  <= 1'b0;
         rd_val   <= '0;
      end else begin
         cfg_ever <= cfg_ever | cfg_done;
         rd_val   <= rsp_rdata[IN_W-1:0];
         if (req_valid && req_ack) begin
            busy    <= 1'b1;
            busy_rd <= req_rd;
         end else if (rsp_done) begin
            busy <= 1'b0;
         end
      end
   end

   // R2
   no_pre_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ever |-> !req_valid);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ack) |=> (req_valid && $stable(req_rd) && $stable(req_cmd)
                                   && $stable(req_wdata) && $stable(req_addr)));

   // R9
   one_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_valid);

   // R11
   dev_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_addr == DEV_ADDR));

   // R10
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsp_done && rsp_err) |=> err_sticky);

   // R10
   err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   // R10
   sts_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_err) |=> $stable(hp_sts));

   // R6
   sts_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_rd && rsp_done && !rsp_err) |=> (hp_sts == rd_val));

   // R4
   wd_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_rd) |-> ((req_wdata >> OUT_W) == 16'd0));
endmodule

bind hpx_sync hpx_sync_chk #(
   .OUT_W    (OUT_W),
   .IN_W     (IN_W),
   .DEV_ADDR (DEV_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_done   (cfg_done),
   .hp_sts     (hp_sts),
   .err_sticky (err_sticky),
   .req_valid  (req_valid),
   .req_ack    (req_ack),
   .req_addr   (req_addr),
   .req_rd     (req_rd),
   .req_cmd    (req_cmd),
   .req_wdata  (req_wdata),
   .rsp_done   (rsp_done),
   .rsp_err    (rsp_err),
   .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_hpx_sync.sv
`timescale 1ns/1ps
module tb_hpx_sync;
   localparam int unsigned OW  = 4;
   localparam int unsigned IW  = 4;
   localparam logic [6:0]  ADR = 7'h27;
   localparam logic [7:0]  WRC = 8'h03;
   localparam logic [7:0]  RDC = 8'h01;
   localparam int          LAT = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_done = 1'b0;
   logic [OW-1:0] hp_ctl = '0;
   logic          exp_int_n = 1'b1;
   logic [IW-1:0] hp_sts;
   logic          err_sticky;
   logic          req_valid;
   logic          req_ack = 1'b0;
   logic [6:0]    req_addr;
   logic          req_rd;
   logic [7:0]    req_cmd;
   logic [15:0]   req_wdata;
   logic          rsp_done = 1'b0;
   logic          rsp_err = 1'b0;
   logic [15:0]   rsp_rdata = '0;

   int            n_chk = 0;
   int            n_bad = 0;
   int            n_log = 0;
   logic          lg_rd   [0:255];
   logic [7:0]    lg_cmd  [0:255];
   logic [6:0]    lg_adr  [0:255];
   logic [15:0]   lg_data [0:255];
   logic [IW-1:0] exp_in = '0;
   int            int_hold = 0;
   int            err_budget = 0;
   int            stab_bad = 0;
   int            overlap_bad = 0;
   bit            finished = 1'b0;

   always #10 clk = ~clk;

   hpx_sync #(.OUT_W(OW), .IN_W(IW), .DEV_ADDR(ADR), .WR_CMD(WRC), .RD_CMD(RDC)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .hp_ctl(hp_ctl),
      .exp_int_n(exp_int_n), .hp_sts(hp_sts), .err_sticky(err_sticky),
      .req_valid(req_valid), .req_ack(req_ack), .req_addr(req_addr),
      .req_rd(req_rd), .req_cmd(req_cmd), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (60) @(negedge clk);
   endtask

   task automatic chk_entry(input string tag, input int idx, input logic rd, input int data);
      chk({tag, " kind"}, int'(lg_rd[idx]), int'(rd));
      chk({tag, " cmd"},  int'(lg_cmd[idx]), rd ? int'(RDC) : int'(WRC));
      chk({tag, " addr R11"}, int'(lg_adr[idx]), int'(ADR));
      if (!rd) chk({tag, " data"}, int'(lg_data[idx]), data);
   endtask

   // SMBus engine model
   initial begin
      logic          c_rd;
      logic [7:0]    c_cmd;
      logic [6:0]    c_adr;
      logic [15:0]   c_wd;
      forever begin
         @(negedge clk);
         if (req_valid) begin
            c_rd = req_rd; c_cmd = req_cmd; c_adr = req_addr; c_wd = req_wdata;
            @(negedge clk);
            if (!req_valid || req_rd != c_rd || req_cmd != c_cmd ||
                req_addr != c_adr || req_wdata != c_wd) stab_bad++;
            req_ack = 1'b1;
            if (c_rd) begin
               if (int_hold > 0) int_hold--;
               else exp_int_n = 1'b1;
            end
            @(negedge clk);
            req_ack = 1'b0;
            for (int k = 0; k < LAT; k++) begin
               @(negedge clk);
               if (req_valid) overlap_bad++;
            end
            rsp_done  = 1'b1;
            rsp_err   = (err_budget > 0);
            if (err_budget > 0) err_budget--;
            rsp_rdata = {12'hA5C, exp_in};
            lg_rd[n_log] = c_rd; lg_cmd[n_log] = c_cmd;
            lg_adr[n_log] = c_adr; lg_data[n_log] = c_wd;
            n_log++;
            @(negedge clk);
            rsp_done = 1'b0;
            rsp_err  = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int base;
      int prev;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 req_valid", int'(req_valid), 0);
      chk("R1 hp_sts", int'(hp_sts), 0);
      chk("R1 err_sticky", int'(err_sticky), 0);
      rst_n = 1'b1;

      // R2: nothing before configuration completes
      hp_ctl = 4'h5; exp_in = 4'hA;
      repeat (10) @(negedge clk);
      exp_int_n = 1'b0;
      repeat (10) @(negedge clk);
      exp_int_n = 1'b1;
      hp_ctl = 4'h6;
      repeat (10) @(negedge clk);
      chk("R2 no traffic before cfg_done", n_log, 0);

      // R3: initial write then read
      cfg_done = 1'b1;
      settle();
      chk("R3 initial count", n_log, 2);
      chk_entry("R3 first write", 0, 1'b0, 6);
      chk_entry("R3 second read", 1, 1'b1, 0);
      chk("R6 initial status", int'(hp_sts), 'hA);
      chk("R10 no error yet", int'(err_sticky), 0);

      // R4: sweep every output value
      prev = 6;
      for (int v = 0; v < 16; v++) begin
         if (v == prev) continue;
         base = n_log;
         hp_ctl = OW'(v);
         settle();
         chk("R4 one write per change", n_log - base, 1);
         chk_entry("R4 full vector write", base, 1'b0, v);
         prev = v;
      end

      // R6: sweep every input value via interrupt
      for (int v = 0; v < 16; v++) begin
         base = n_log;
         exp_in = IW'(v);
         exp_int_n = 1'b0;
         settle();
         chk("R6 one read per interrupt", n_log - base, 1);
         chk_entry("R6 read", base, 1'b1, 0);
         chk("R6 status loaded", int'(hp_sts), v);
      end

      // R5: change during a write
      base = n_log;
      hp_ctl = 4'h1;
      while (!req_valid) @(negedge clk);
      repeat (2) @(negedge clk);
      hp_ctl = 4'h9;
      settle();
      chk("R5 two writes", n_log - base, 2);
      chk_entry("R5 first write", base, 1'b0, 1);
      chk_entry("R5 dirty rewrite", base + 1, 1'b0, 9);

      // R8: read and write pending together
      base = n_log;
      exp_in = 4'h6;
      exp_int_n = 1'b0;
      repeat (2) @(negedge clk);
      hp_ctl = 4'h3;
      settle();
      chk("R8 count", n_log - base, 2);
      chk_entry("R8 write first", base, 1'b0, 3);
      chk_entry("R8 read second", base + 1, 1'b1, 0);
      chk("R8 status", int'(hp_sts), 6);

      // R7: line held low across one read
      base = n_log;
      exp_in = 4'hC;
      int_hold = 1;
      exp_int_n = 1'b0;
      settle();
      chk("R7 re-read while low", n_log - base, 2);
      chk_entry("R7 second read", base + 1, 1'b1, 0);
      chk("R7 status", int'(hp_sts), 'hC);

      // R10: write failing twice -> exactly one retry
      base = n_log;
      err_budget = 2;
      hp_ctl = 4'hE;
      settle();
      chk("R10 write retried once", n_log - base, 2);
      chk_entry("R10 retry same write", base + 1, 1'b0, 'hE);
      chk("R10 sticky set", int'(err_sticky), 1);

      // R10: read failing once -> retry succeeds
      base = n_log;
      err_budget = 1;
      exp_in = 4'h3;
      exp_int_n = 1'b0;
      settle();
      chk("R10 read retry count", n_log - base, 2);
      chk("R10 retried read loads", int'(hp_sts), 3);

      // R10: read failing twice -> status kept
      base = n_log;
      err_budget = 2;
      exp_in = 4'hB;
      exp_int_n = 1'b0;
      settle();
      chk("R10 failed read count", n_log - base, 2);
      chk("R10 status kept", int'(hp_sts), 3);
      chk("R10 sticky held", int'(err_sticky), 1);

      // R9: handshake discipline seen by the engine model
      chk("R9 fields held until ack", stab_bad, 0);
      chk("R9 single transaction in flight", overlap_bad, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule